// File: doc/BRIEF.md
# I2C Master Byte Receiver

This block is the receive side of an I2C master. Once a start condition and an address phase have been handled elsewhere, the CPU asks for one byte. The block then generates eight SCL pulses from a programmable baud divider, collects the eight SDA levels most significant bit first, and moves the finished byte into a CPU-readable buffer. At the end it raises a buffer-full flag and an interrupt flag, and it keeps SCL pulled low until it receives the next command.

The CPU can then ask for one acknowledge bit. The block drives SDA low (ACK) or leaves it released (NACK) for one full clock pulse, parks SCL low again and raises the interrupt flag. Two sticky error flags record problems. An overrun is a byte that completes while the buffer still holds an unread one. A write collision is a CPU write to the buffer during shifting. SCL and SDA are open drain: each `*_oe_o` output set to 1 pulls its line low.

Top module: `i2c_byte_receiver`

## Requirements
- R1: A receive or acknowledge request is taken only while the block is idle. A request made during a byte or an acknowledge changes neither the sequence nor its length.
- R2: After a receive request, SCL goes through 8 low/high pairs. It starts low, and each half period lasts DIV+1 clock cycles, where DIV is the divider value. `rx_busy_o` is high for exactly 16*(DIV+1) cycles.
- R3: The SDA level present at the end of each SCL high phase becomes the next bit. The first bit lands in bit 7 of the byte and the last in bit 0.
- R4: When the eighth high phase ends, SCL is pulled low (`scl_oe_o`=1) and `rx_busy_o` clears. In the same edge the byte enters `rd_data_o` and `full_o` and `irq_o` are set. SCL stays pulled low while the block is idle.
- R5: A `buf_re_i` strobe clears `full_o`. `full_o` stays set until that strobe.
- R6: If a byte completes while `full_o` is 1, `ovf_o` is set and `rd_data_o` keeps the older byte.
- R7: A `buf_we_i` strobe while `rx_busy_o` is 1 sets `wcol_o` and leaves `rd_data_o` unchanged. The same strobe while idle loads `buf_wdata_i` into `rd_data_o`.
- R8: An acknowledge runs three phases of DIV+1 cycles each: SCL low, SCL high, SCL low. `sda_oe_o` equals NOT `ack_nack_i` (sampled at the request) for the whole sequence. After it, `sda_oe_o`=0, `scl_oe_o`=1, `ack_busy_o`=0 and `irq_o`=1.
- R9: `ovf_o` and `wcol_o` clear only on `err_clr_i`, and `irq_o` clears only on `irq_clr_i`. A new setting event in the same cycle wins.
- R10: `div_wdata_i` written with `div_we_i` sets DIV. The new DIV applies to every phase of a later receive or acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_req_i | input | 1 | Receive-one-byte request strobe |
| ack_req_i | input | 1 | Acknowledge-bit request strobe |
| ack_nack_i | input | 1 | Acknowledge level: 0 = ACK (low), 1 = NACK (released) |
| div_we_i | input | 1 | Divider register write strobe |
| div_wdata_i | input | DIV_W | Divider value (half period = value+1 cycles) |
| buf_we_i | input | 1 | CPU write strobe to the data buffer |
| buf_wdata_i | input | DATA_W | CPU write data |
| buf_re_i | input | 1 | CPU read strobe of the data buffer |
| err_clr_i | input | 1 | Clears overrun and write-collision flags |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| rd_data_o | output | DATA_W | Data buffer |
| full_o | output | 1 | Buffer holds an unread byte |
| irq_o | output | 1 | Interrupt flag |
| ovf_o | output | 1 | Sticky overrun flag |
| wcol_o | output | 1 | Sticky write-collision flag |
| rx_busy_o | output | 1 | Receive enable, self-clearing |
| ack_busy_o | output | 1 | Acknowledge in progress, self-clearing |

## Verification
Every one of the 256 byte values is received at one divider setting, so any swap, shift or stuck bit position shows up in the assembled byte. A second pass uses divider values from 0 to 4 with walking-one and alternating patterns. Each pass counts busy and SCL-high cycles, which separates an off-by-one in the counter reload from a wrong phase count. Further runs inject receive, acknowledge and buffer-write strobes in the middle of a byte, receive two bytes back to back with no read between them, and issue both ACK and NACK acknowledges. These runs show that busy-time requests are ignored, that the older byte survives an overrun and that each flag stays set until its own clear.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX_LO,
    ST_RX_HI,
    ST_ACK_LO,
    ST_ACK_HI,
    ST_ACK_TAIL
  } rxm_state_e;
endpackage

// File: rtl/rxm_baud.sv
module rxm_baud #(
  parameter int DIV_W = 8,
  parameter logic [DIV_W-1:0] DIV_RST = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             div_we_i,
  input  logic [DIV_W-1:0] div_wdata_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= DIV_RST;
    else if (div_we_i) div_q <= div_wdata_i;
  end

  // frozen at the reload value while not running
  always_ff @(posedge clk) begin
    if (rst) cnt_q <= DIV_RST;
    else if (!run_i || cnt_q == '0) cnt_q <= div_q;
    else cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = run_i && (cnt_q == '0);

  // a rollover is followed by at least one idle count unless DIV is zero
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_o && div_q != '0 && !div_we_i) |=> !tick_o);
endmodule

// File: rtl/rxm_seq.sv
module rxm_seq
  import rxm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              rx_req_i,
  input  logic              ack_req_i,
  input  logic              ack_nack_i,
  input  logic              sda_i,
  output logic              run_o,
  output logic              rx_busy_o,
  output logic              ack_busy_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              byte_done_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              ack_done_o
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  rxm_state_e        st_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      bit_q <= '0;
      sh_q  <= '0;
      scl_q <= 1'b0;
      sda_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (rx_req_i) begin
            st_q  <= ST_RX_LO;
            scl_q <= 1'b1;
            bit_q <= '0;
          end else if (ack_req_i) begin
            st_q  <= ST_ACK_LO;
            scl_q <= 1'b1;
            sda_q <= ~ack_nack_i;
          end
        end
        ST_RX_LO: begin
          if (tick_i) begin
            scl_q <= 1'b0;
            st_q  <= ST_RX_HI;
          end
        end
        ST_RX_HI: begin
          if (tick_i) begin
            scl_q <= 1'b1;
            sh_q  <= byte_o;
            if (bit_q == LAST_BIT) begin
              st_q <= ST_IDLE;
            end else begin
              bit_q <= bit_q + 1'b1;
              st_q  <= ST_RX_LO;
            end
          end
        end
        ST_ACK_LO: begin
          if (tick_i) begin
            scl_q <= 1'b0;
            st_q  <= ST_ACK_HI;
          end
        end
        ST_ACK_HI: begin
          if (tick_i) begin
            scl_q <= 1'b1;
            st_q  <= ST_ACK_TAIL;
          end
        end
        ST_ACK_TAIL: begin
          if (tick_i) begin
            sda_q <= 1'b0;
            st_q  <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  generate
    if (DATA_W > 1) begin : g_wide
      assign byte_o = {sh_q[DATA_W-2:0], sda_i};
    end else begin : g_one
      assign byte_o = sda_i;
    end
  endgenerate

  assign run_o       = (st_q != ST_IDLE);
  assign rx_busy_o   = (st_q == ST_RX_LO) || (st_q == ST_RX_HI);
  assign ack_busy_o  = (st_q == ST_ACK_LO) || (st_q == ST_ACK_HI) || (st_q == ST_ACK_TAIL);
  assign byte_done_o = (st_q == ST_RX_HI) && tick_i && (bit_q == LAST_BIT);
  assign ack_done_o  = (st_q == ST_ACK_TAIL) && tick_i;
  assign scl_oe_o    = scl_q;
  assign sda_oe_o    = sda_q;

  assert_busy_req_ignored_R1: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RX_HI && !tick_i && (rx_req_i || ack_req_i)) |=> (st_q == ST_RX_HI));

  assert_park_low_R4: assert property (@(posedge clk) disable iff (rst)
    byte_done_o |=> (scl_oe_o && !rx_busy_o));

  assert_ack_level_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ACK_HI) |=> $stable(sda_oe_o));

  assert_rx_no_sda_drive_R3: assert property (@(posedge clk) disable iff (rst)
    rx_busy_o |-> !sda_oe_o);
endmodule

// File: rtl/i2c_byte_receiver.sv
module i2c_byte_receiver #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter logic [DIV_W-1:0] DIV_RST = DIV_W'(3)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_req_i,
  input  logic              ack_req_i,
  input  logic              ack_nack_i,
  input  logic              div_we_i,
  input  logic [DIV_W-1:0]  div_wdata_i,
  input  logic              buf_we_i,
  input  logic [DATA_W-1:0] buf_wdata_i,
  input  logic              buf_re_i,
  input  logic              err_clr_i,
  input  logic              irq_clr_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              full_o,
  output logic              irq_o,
  output logic              ovf_o,
  output logic              wcol_o,
  output logic              rx_busy_o,
  output logic              ack_busy_o
);
  logic              run;
  logic              tick;
  logic              rx_busy;
  logic              byte_done;
  logic              ack_done;
  logic [DATA_W-1:0] byte_in;

  rxm_baud #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_baud (
    .clk         (clk),
    .rst         (rst),
    .run_i       (run),
    .div_we_i    (div_we_i),
    .div_wdata_i (div_wdata_i),
    .tick_o      (tick)
  );

  rxm_seq #(.DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick),
    .rx_req_i    (rx_req_i),
    .ack_req_i   (ack_req_i),
    .ack_nack_i  (ack_nack_i),
    .sda_i       (sda_i),
    .run_o       (run),
    .rx_busy_o   (rx_busy),
    .ack_busy_o  (ack_busy_o),
    .scl_oe_o    (scl_oe_o),
    .sda_oe_o    (sda_oe_o),
    .byte_done_o (byte_done),
    .byte_o      (byte_in),
    .ack_done_o  (ack_done)
  );

  logic [DATA_W-1:0] rd_q;
  logic full_q, irq_q, ovf_q, wcol_q;

  // later statements win: setting events override clears
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= '0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
      ovf_q  <= 1'b0;
      wcol_q <= 1'b0;
    end else begin
      if (irq_clr_i) irq_q <= 1'b0;
      if (byte_done || ack_done) irq_q <= 1'b1;
      if (err_clr_i) begin
        ovf_q  <= 1'b0;
        wcol_q <= 1'b0;
      end
      if (buf_re_i) full_q <= 1'b0;
      if (buf_we_i) begin
        if (rx_busy) wcol_q <= 1'b1;
        else rd_q <= buf_wdata_i;
      end
      if (byte_done) begin
        if (full_q) begin
          ovf_q <= 1'b1;
        end else begin
          rd_q   <= byte_in;
          full_q <= 1'b1;
        end
      end
    end
  end

  assign rd_data_o = rd_q;
  assign full_o    = full_q;
  assign irq_o     = irq_q;
  assign ovf_o     = ovf_q;
  assign wcol_o    = wcol_q;
  assign rx_busy_o = rx_busy;

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (buf_re_i && !byte_done) |=> !full_q);

  assert_full_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (full_q && !buf_re_i) |=> full_q);

  assert_overrun_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    (byte_done && full_q) |=> (ovf_q && $stable(rd_q)));

  assert_collision_R7: assert property (@(posedge clk) disable iff (rst)
    (buf_we_i && rx_busy && !byte_done) |=> (wcol_q && $stable(rd_q)));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !err_clr_i) |=> ovf_q);

  assert_wcol_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (wcol_q && !err_clr_i) |=> wcol_q);

  assert_irq_on_done_R4: assert property (@(posedge clk) disable iff (rst)
    (byte_done || ack_done) |=> irq_q);
endmodule

// File: tb/i2c_byte_receiver_test.sv
module i2c_byte_receiver_test;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_req_i = 0, ack_req_i = 0, ack_nack_i = 0;
  logic div_we_i = 0;
  logic [DIV_W-1:0] div_wdata_i = '0;
  logic buf_we_i = 0;
  logic [DATA_W-1:0] buf_wdata_i = '0;
  logic buf_re_i = 0, err_clr_i = 0, irq_clr_i = 0;
  logic sda_i = 1'b1;
  logic scl_oe_o, sda_oe_o, full_o, irq_o, ovf_o, wcol_o, rx_busy_o, ack_busy_o;
  logic [DATA_W-1:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_byte_receiver #(.DATA_W(DATA_W), .DIV_W(DIV_W), .DIV_RST(DIV_W'(1))) uut (
    .clk(clk), .rst(rst), .rx_req_i(rx_req_i), .ack_req_i(ack_req_i),
    .ack_nack_i(ack_nack_i), .div_we_i(div_we_i), .div_wdata_i(div_wdata_i),
    .buf_we_i(buf_we_i), .buf_wdata_i(buf_wdata_i), .buf_re_i(buf_re_i),
    .err_clr_i(err_clr_i), .irq_clr_i(irq_clr_i), .sda_i(sda_i),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .rd_data_o(rd_data_o),
    .full_o(full_o), .irq_o(irq_o), .ovf_o(ovf_o), .wcol_o(wcol_o),
    .rx_busy_o(rx_busy_o), .ack_busy_o(ack_busy_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic strobe(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic set_div(input int d);
    @(negedge clk); div_we_i = 1'b1; div_wdata_i = DIV_W'(d);
    @(negedge clk); div_we_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // receive one byte; optionally poke requests and a buffer write mid-byte
  task automatic recv(input logic [7:0] b, input bit poke,
                      output int busy_n, output int hi_n, output int mid_rd);
    int bn = 0, hn = 0, mr = -1;
    @(negedge clk); sda_i = b[7]; rx_req_i = 1'b1;
    @(negedge clk); rx_req_i = 1'b0;
    fork
      begin
        for (int i = 6; i >= 0; i--) begin
          @(negedge scl_oe_o);
          @(posedge scl_oe_o);
          #1 sda_i = b[i];
        end
      end
      begin
        while (rx_busy_o) begin
          if (!scl_oe_o) hn++;
          bn++;
          if (poke && bn == 4) begin
            rx_req_i = 1; ack_req_i = 1; buf_we_i = 1; buf_wdata_i = ~b;
          end else begin
            rx_req_i = 0; ack_req_i = 0; buf_we_i = 0;
          end
          if (poke && bn == 6) mr = rd_data_o;
          @(negedge clk);
        end
        rx_req_i = 0; ack_req_i = 0; buf_we_i = 0;
      end
    join
    busy_n = bn; hi_n = hn; mid_rd = mr;
  endtask

  task automatic do_ack(input bit nack, input int d);
    int bn = 0, held = 0;
    @(negedge clk); ack_nack_i = nack; ack_req_i = 1'b1;
    @(negedge clk); ack_req_i = 1'b0;
    while (ack_busy_o) begin
      if (!scl_oe_o && (sda_oe_o == !nack)) held++;
      if (sda_oe_o != !nack) held = -1000;
      bn++;
      @(negedge clk);
    end
    check("R8 ack duration", bn, 3 * (d + 1));
    check("R8 level held over high phase", held, d + 1);
    check("R8 sda released after", sda_oe_o, 0);
    check("R8 scl parked low", scl_oe_o, 1);
    check("R8 irq raised", irq_o, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int bn, hn, mr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("reset full", full_o, 0);
    check("reset irq", irq_o, 0);
    check("reset ovf", ovf_o, 0);
    check("reset wcol", wcol_o, 0);
    check("reset busy", rx_busy_o, 0);
    check("reset scl", scl_oe_o, 0);
    check("reset sda", sda_oe_o, 0);

    // R3 R4 R5: every byte value at DIV=1
    for (int v = 0; v < 256; v++) begin
      recv(8'(v), 0, bn, hn, mr);
      check("R2 busy length", bn, 32);
      check("R3 byte value", rd_data_o, v);
      check("R4 full set", full_o, 1);
      check("R4 irq set", irq_o, 1);
      check("R4 scl parked", scl_oe_o, 1);
      strobe(buf_re_i);
      check("R5 read clears full", full_o, 0);
      check("R9 irq still set before clear", irq_o, 1);
      strobe(irq_clr_i);
      check("R9 irq cleared", irq_o, 0);
    end

    // R2 R10: divider sweep
    for (int d = 0; d <= 4; d++) begin
      set_div(d);
      for (int k = 0; k < 4; k++) begin
        logic [7:0] pat;
        pat = (k == 0) ? 8'hA5 : (k == 1) ? 8'h5A : (k == 2) ? 8'h01 : 8'h80;
        recv(pat, 0, bn, hn, mr);
        check("R10 busy length per divider", bn, 16 * (d + 1));
        check("R2 scl high cycles", hn, 8 * (d + 1));
        check("R3 byte value", rd_data_o, pat);
        strobe(buf_re_i);
      end
    end

    // R1 R7: requests and a buffer write during reception
    set_div(2);
    strobe(irq_clr_i);
    recv(8'h3C, 1, bn, hn, mr);
    check("R1 busy length unaffected", bn, 48);
    check("R7 buffer unchanged mid-byte", mr, 8'h80);
    check("R7 wcol set", wcol_o, 1);
    check("R7 received byte", rd_data_o, 8'h3C);
    repeat (10) @(negedge clk);
    check("R1 no restart", rx_busy_o, 0);
    check("R1 no ack started", ack_busy_o, 0);
    check("R4 scl held low idle", scl_oe_o, 1);
    strobe(buf_re_i);
    check("R9 wcol sticky over read", wcol_o, 1);
    strobe(err_clr_i);
    check("R9 wcol cleared", wcol_o, 0);
    strobe(buf_we_i);
    check("R7 idle write loads buffer", rd_data_o, 8'hC3);
    @(negedge clk); buf_wdata_i = 8'h77; buf_we_i = 1;
    @(negedge clk); buf_we_i = 0;
    check("R7 idle write data", rd_data_o, 8'h77);
    check("R7 no wcol when idle", wcol_o, 0);
    check("R7 full untouched", full_o, 0);

    // R6: overrun
    recv(8'h11, 0, bn, hn, mr);
    check("R6 first byte", rd_data_o, 8'h11);
    recv(8'h22, 0, bn, hn, mr);
    check("R6 ovf set", ovf_o, 1);
    check("R6 older byte kept", rd_data_o, 8'h11);
    check("R6 full stays", full_o, 1);
    strobe(buf_re_i);
    check("R9 ovf sticky over read", ovf_o, 1);
    strobe(irq_clr_i);
    check("R9 ovf sticky over irq clear", ovf_o, 1);
    strobe(err_clr_i);
    check("R9 ovf cleared", ovf_o, 0);

    // R8: ACK and NACK
    strobe(irq_clr_i);
    do_ack(0, 2);
    strobe(irq_clr_i);
    set_div(0);
    do_ack(1, 0);
    strobe(irq_clr_i);
    set_div(3);
    do_ack(0, 3);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule